// File: doc/BRIEF.md
# Four-Queue Shared-Memory Buffer with Addressed Port Selection

The block keeps four independent first-in first-out queues in one shared storage array. Each queue owns a fixed region of `QDEPTH` words. Everything runs on a single clock. The write side and the read side each hold their own "current queue". A port changes its queue only on a clock edge where its address enable is high. The 6-bit port address splits into three fields:

- bits [1:0]: the queue index.
- bit [2]: a null-queue flag.
- bits [5:3]: a device identifier, compared with the `DEV_ID` parameter.

A port that holds the null queue, or a mismatched identifier, is idle: it moves no data.

Data moves over two valid/ready streams:

- **Write stream.** A word is taken on an edge where `wr_valid` and `wr_ready` are both high. `wr_ready` stays low while the selected write queue is full or the port is idle. The source may hold `wr_valid` high for any length of time.
- **Read stream.** The oldest word of the selected read queue is presented on `rd_data`. It is consumed on an edge where `rd_valid` and `rd_ready` are both high. `rd_valid` stays low while that queue is empty, the port is idle, or the output is disabled by `out_en_n` high. A word is never consumed without `rd_ready`.

A one-cycle active-low pulse on `prst_n` empties the queue that both ports currently hold. It rewinds that queue's two pointers to the start of its region. The pulse is honoured only when both ports settled on that queue at least two edges before the pulse. If a write or read on that queue coincides with the pulse, the pulse wins. Two active-low flags report the fill level of the selected queues:

- `ae_n` shows the almost-empty level of the read-side queue.
- `af_n` shows the almost-full level of the write-side queue.

Top module: `quad_queue_buf`

## Requirements
- R1: On an edge with the address enable high and `cfg_done` high, a port adopts its address. The queue is bits [1:0]. The selection is usable only when bit [2] is 0 and bits [5:3] equal `DEV_ID`.
- R2: After reset neither port holds a queue, so `wr_ready`=0, `rd_valid`=0, `ae_n`=1 and `af_n`=1. While `cfg_done` is low, address enables are ignored.
- R3: A word offered while `wr_ready` is high is appended to the selected write queue. `wr_ready` is 0 once that queue holds `QDEPTH` words.
- R4: `rd_valid` is 1 while the selected read queue is non-empty and `out_en_n` is 0, and `rd_data` then shows its oldest word. Each queue keeps its own first-in first-out order, whatever traffic the other queues carry.
- R5: A port holding the null queue or a wrong identifier moves no data and changes no pointer. Queue contents survive until the port is re-pointed at a valid queue.
- R6: `prst_n`=0 on an edge empties the common queue of both ports, provided each port's selection edge lies at least two edges earlier. The other queues are untouched, and the emptied queue can be reused at once.
- R7: A `prst_n` pulse is ignored when the ports hold different queues, or when either selection is younger than two edges.
- R8: `ae_n` is 0 when the read port holds a valid queue containing at most `AE_THR` words. Otherwise it is 1.
- R9: `af_n` is 0 when the write port holds a valid queue containing at least `QDEPTH-AF_THR` words. Otherwise it is 1.
- R10: While `out_en_n` is 1, `rd_valid` is 0, `rd_data` is all zeros and no word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration finished; selections accepted only when high |
| wr_addr_en | input | 1 | Write-side address enable |
| wr_addr | input | 6 | Write-side queue address |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken |
| wr_data | input | DATA_W | Write word |
| rd_addr_en | input | 1 | Read-side address enable |
| rd_addr | input | 6 | Read-side queue address |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A word is presented |
| rd_data | output | DATA_W | Oldest word of the read-side queue |
| out_en_n | input | 1 | Active-low output enable |
| prst_n | input | 1 | Active-low single-queue pointer reset |
| ae_n | output | 1 | Almost-empty, active low, read-side queue |
| af_n | output | 1 | Almost-full, active low, write-side queue |

## Verification
The main data path is driven with four patterns, each aimed at a different fault:

- **Fill and drain of one queue.** One queue is filled to capacity and drained. This separates correct wrap and full blocking from pointer overrun, and it walks both flag thresholds one word at a time.
- **Interleaved queues.** Two queues are written in alternation and read back in the opposite order. This exposes region-address mix-ups that a single queue would hide.
- **Idle selections.** Data is offered while a port holds a null or foreign address. This tells a true no-op from a silent write into queue 0.
- **Partial-reset pulses.** Pulses are sent with settled selections, with fresh selections and with mismatched selections. This distinguishes the timing precondition from an unconditional clear.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
  localparam int NQ     = 4;
  localparam int ADDR_W = 6;
  localparam int QIX_W  = 2;
  localparam int DEV_W  = 3;

  typedef struct packed {
    logic             ok;
    logic [QIX_W-1:0] idx;
  } qsel_t;
endpackage

// File: rtl/qbuf_sel.sv
module qbuf_sel
  import qbuf_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              addr_en,
  input  logic [ADDR_W-1:0] addr,
  output qsel_t             sel,
  output logic              settled
);
  logic [1:0] age;
  logic       take;

  assign take    = addr_en && cfg_done;
  assign settled = (age == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      age <= 2'd0;
    end else if (take) begin
      sel.ok  <= !addr[QIX_W] && (addr[ADDR_W-1 -: DEV_W] == DEV_ID);
      sel.idx <= addr[QIX_W-1:0];
      age     <= 2'd1;
    end else if (age != 2'd2) begin
      age <= age + 2'd1;
    end
  end

  // R2: address enables before configuration completes leave selection as is
  a_r2_hold_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !cfg_done) |=> $stable(sel));
endmodule

// File: rtl/qbuf_qptr.sv
module qbuf_qptr #(
  parameter int QDEPTH = 8,
  localparam int AW = $clog2(QDEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic [CW-1:0] wptr,
  output logic [CW-1:0] rptr,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL_LVL = CW'(QDEPTH);

  assign cnt = wptr - rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
    end
  end

  // R3: occupancy never leaves 0..QDEPTH (covers overflow and underflow)
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_LVL);

  // R6: an accepted partial reset leaves the queue empty at its region start
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0) && (rptr == '0));
endmodule

// File: rtl/quad_queue_buf.sv
module quad_queue_buf
  import qbuf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int QDEPTH = 8,
  parameter logic [2:0] DEV_ID = 3'd5,
  parameter int AE_THR = 2,
  parameter int AF_THR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_done,
  input  logic              wr_addr_en,
  input  logic [5:0]        wr_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr_en,
  input  logic [5:0]        rd_addr,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              out_en_n,
  input  logic              prst_n,
  output logic              ae_n,
  output logic              af_n
);
  localparam int AW = $clog2(QDEPTH);
  localparam int CW = AW + 1;
  localparam int MEM_N = NQ * QDEPTH;
  localparam logic [CW-1:0] FULL_LVL = CW'(QDEPTH);
  localparam logic [CW-1:0] AE_LVL   = CW'(AE_THR);
  localparam logic [CW-1:0] AF_LVL   = CW'(QDEPTH - AF_THR);

  qsel_t wsel, rsel;
  logic  wset, rset;

  logic [NQ-1:0][CW-1:0] wptr_v, rptr_v, cnt_v;
  logic [NQ-1:0]         push_v, pop_v, clr_v;

  logic              wr_fire, rd_fire, pr_ok;
  logic [CW-1:0]     wcnt, rcnt;
  logic [DATA_W-1:0] mem [MEM_N];

  qbuf_sel #(.DEV_ID(DEV_ID)) u_wsel (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
    .addr_en(wr_addr_en), .addr(wr_addr), .sel(wsel), .settled(wset)
  );

  qbuf_sel #(.DEV_ID(DEV_ID)) u_rsel (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
    .addr_en(rd_addr_en), .addr(rd_addr), .sel(rsel), .settled(rset)
  );

  assign wcnt = cnt_v[wsel.idx];
  assign rcnt = cnt_v[rsel.idx];

  assign wr_ready = wsel.ok && (wcnt != FULL_LVL);
  assign rd_valid = rsel.ok && !out_en_n && (rcnt != '0);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  // partial reset precondition: same valid queue on both sides, both settled
  assign pr_ok = !prst_n && wsel.ok && rsel.ok && (wsel.idx == rsel.idx)
                 && wset && rset;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign push_v[q] = wr_fire && (wsel.idx == QIX_W'(q));
    assign pop_v[q]  = rd_fire && (rsel.idx == QIX_W'(q));
    assign clr_v[q]  = pr_ok   && (wsel.idx == QIX_W'(q));

    qbuf_qptr #(.QDEPTH(QDEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .push(push_v[q]), .pop(pop_v[q]), .clr(clr_v[q]),
      .wptr(wptr_v[q]), .rptr(rptr_v[q]), .cnt(cnt_v[q])
    );
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[{wsel.idx, wptr_v[wsel.idx][AW-1:0]}] <= wr_data;
  end

  assign rd_data = out_en_n ? '0 : mem[{rsel.idx, rptr_v[rsel.idx][AW-1:0]}];

  assign ae_n = !(rsel.ok && (rcnt <= AE_LVL));
  assign af_n = !(wsel.ok && (wcnt >= AF_LVL));

  // R5: an idle write port leaves every write pointer where it was
  a_r5_wr_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel.ok |=> $stable(wptr_v));

  // R5: an idle read port leaves every read pointer where it was
  a_r5_rd_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !rsel.ok |=> $stable(rptr_v));

  // R10: a disabled output consumes nothing
  a_r10_oe_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_n && prst_n) |=> $stable(rptr_v));

  // R7: a pulse across two different queues clears no pointer pair
  a_r7_mismatch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!prst_n && (wsel.idx != rsel.idx) && !wr_fire && !rd_fire)
      |=> $stable(wptr_v) && $stable(rptr_v));
endmodule

// File: tb/tb_quad_queue_buf.sv
`timescale 1ns/1ps
module tb_quad_queue_buf;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n, cfg_done, wr_addr_en, wr_valid, rd_addr_en, rd_ready;
  logic out_en_n, prst_n;
  logic [5:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic wr_ready, rd_valid, ae_n, af_n;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  quad_queue_buf dut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
    .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .out_en_n(out_en_n), .prst_n(prst_n), .ae_n(ae_n), .af_n(af_n)
  );

  typedef logic [DW-1:0] item_q_t [$];
  item_q_t exp_q [4];
  int n_chk = 0, n_fail = 0;
  int cur_wq = 0, cur_rq = 0;
  bit done = 0;

  function automatic logic [5:0] mk(input int idx, input bit nul, input int dev);
    return {3'(dev), nul, 2'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every task starts and ends 1 ns after a rising edge
  task automatic sel_wr(input logic [5:0] a, input int q);
    wr_addr = a; wr_addr_en = 1'b1;
    @(posedge clk); #1 wr_addr_en = 1'b0;
    cur_wq = q;
  endtask

  task automatic sel_rd(input logic [5:0] a, input int q);
    rd_addr = a; rd_addr_en = 1'b1;
    @(posedge clk); #1 rd_addr_en = 1'b0;
    cur_rq = q;
  endtask

  task automatic push(input logic [DW-1:0] d);
    bit ok;
    ok = wr_ready;
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
    if (ok) exp_q[cur_wq].push_back(d);
  endtask

  task automatic drain(input int n);
    rd_ready = 1'b1;
    repeat (n) begin @(posedge clk); #1; end
    rd_ready = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_prst();
    prst_n = 1'b0;
    @(posedge clk); #1 prst_n = 1'b1;
  endtask

  // monitor: every consumed word is compared with the scoreboard (R4)
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q[cur_rq].size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4: unexpected word %0h, expected none", rd_data);
      end else begin
        chk("R4 order", 32'(rd_data), 32'(exp_q[cur_rq].pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_done = 0; wr_addr_en = 0; rd_addr_en = 0;
    wr_valid = 0; rd_ready = 0; out_en_n = 0; prst_n = 1;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    chk("R2 wr_ready", 32'(wr_ready), 0);
    chk("R2 rd_valid", 32'(rd_valid), 0);
    chk("R2 ae_n", 32'(ae_n), 1);
    chk("R2 af_n", 32'(af_n), 1);

    // selection before configuration is ignored
    sel_wr(mk(1, 0, 5), 1);
    chk("R2 cfg gate", 32'(wr_ready), 0);
    cfg_done = 1;

    // R1 R3 R8 R9: fill queue 1 to capacity, then drain
    sel_wr(mk(1, 0, 5), 1);
    sel_rd(mk(1, 0, 5), 1);
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R8 ae at 0", 32'(ae_n), 0);
    push(18'h10); push(18'h11);
    chk("R8 ae at 2", 32'(ae_n), 0);
    push(18'h12);
    chk("R8 ae at 3", 32'(ae_n), 1);
    push(18'h13); push(18'h14);
    chk("R9 af at 5", 32'(af_n), 1);
    push(18'h15);
    chk("R9 af at 6", 32'(af_n), 0);
    push(18'h16); push(18'h17);
    chk("R3 full", 32'(wr_ready), 0);
    push(18'h3ffff);
    chk("R4 head", 32'(rd_data), 32'h10);
    drain(8);
    chk("R4 empty", 32'(rd_valid), 0);

    // R4: two queues interleaved, read back in reverse queue order
    sel_wr(mk(2, 0, 5), 2); push(18'h20); push(18'h21);
    sel_wr(mk(3, 0, 5), 3); push(18'h30); push(18'h31);
    sel_rd(mk(3, 0, 5), 3); drain(2);
    sel_rd(mk(2, 0, 5), 2); drain(2);
    chk("R4 drained", 32'(rd_valid), 0);

    // R10: output disable
    sel_wr(mk(2, 0, 5), 2); push(18'h22);
    out_en_n = 1;
    #0;
    chk("R10 valid", 32'(rd_valid), 0);
    chk("R10 data", 32'(rd_data), 0);
    drain(1);
    out_en_n = 0;
    #0;
    chk("R10 kept", 32'(rd_data), 32'h22);
    drain(1);

    // R5: null and foreign selections on the write side
    sel_wr(mk(0, 1, 5), 0);
    chk("R5 null wr", 32'(wr_ready), 0);
    push(18'h0aa);
    sel_wr(mk(0, 0, 2), 0);
    chk("R5 id wr", 32'(wr_ready), 0);
    push(18'h0bb);
    sel_rd(mk(0, 0, 5), 0);
    chk("R5 no stray", 32'(rd_valid), 0);
    // R5: foreign selection on the read side
    sel_wr(mk(0, 0, 5), 0); push(18'h40); push(18'h41);
    sel_rd(mk(0, 0, 6), 0);
    chk("R5 id rd", 32'(rd_valid), 0);
    chk("R8 idle ae", 32'(ae_n), 1);
    drain(2);
    sel_rd(mk(0, 0, 5), 0);
    chk("R5 survive", 32'(rd_data), 32'h40);
    drain(2);

    // R6: settled partial reset on queue 0, queue 2 untouched
    sel_wr(mk(2, 0, 5), 2); push(18'h23);
    sel_wr(mk(0, 0, 5), 0); push(18'h50); push(18'h51); push(18'h52);
    sel_rd(mk(0, 0, 5), 0);
    idle(2);
    pulse_prst();
    exp_q[0].delete();
    chk("R6 emptied", 32'(rd_valid), 0);
    chk("R6 ae", 32'(ae_n), 0);
    push(18'h53);
    chk("R6 reuse", 32'(rd_data), 32'h53);
    drain(1);
    sel_rd(mk(2, 0, 5), 2);
    chk("R6 other", 32'(rd_data), 32'h23);
    drain(1);

    // R7: fresh read selection, then mismatched queues
    sel_wr(mk(1, 0, 5), 1); push(18'h60);
    sel_rd(mk(1, 0, 5), 1);
    pulse_prst();
    chk("R7 fresh", 32'(rd_valid), 1);
    chk("R7 fresh data", 32'(rd_data), 32'h60);
    sel_wr(mk(3, 0, 5), 3);
    idle(3);
    pulse_prst();
    chk("R7 mismatch", 32'(rd_valid), 1);
    drain(1);
    chk("R4 final", 32'(rd_valid), 0);
    for (int q = 0; q < 4; q++) chk("R4 scoreboard", 32'(exp_q[q].size()), 0);

    idle(2);
    finish_run();
  end
endmodule